// File: doc/BRIEF.md
# Transmit Frame Terminator with Deliberate FCS Corruption

This block sits in the transmit data path of an Ethernet MAC, after preamble handling and before the PHY. It takes frame bytes from a byte-wide valid/ready stream and sends them out one bit per clock, least significant bit first. At the end of a normal frame it appends the 32-bit frame check sequence.

At any point in a frame, the MAC can ask for an orderly stop. The block counts how many data bits of the current frame are already on the wire. If that count is below a threshold (512 by default), the frame is cut off at once and leaves as a runt. If the count has reached the threshold, the block finishes the byte in flight. It then sends the running CRC register without the final complement, so the receiving station is certain to see a bad FCS. In either case a one-cycle completion pulse follows the last bit. A stop request that arrives while no frame is active is answered with the same pulse, and nothing is sent.

Top module: `tx_orderly_abort`

## Requirements
- R1: Out of reset, tx_en and abort_done are low and in_ready is high.
- R2: An uninterrupted frame is sent as its bytes, each least significant bit first. They are followed by 32 bits: the complement of the CRC register, bit 0 first. The CRC register is preset to all ones and updated with the reflected form of polynomial 0x04C11DB7. A frame ends when in_valid is low in the cycle that carries bit 7 of a byte.
- R3: in_ready is high only in two cases. The first is while idle with no stop request. The second is in the cycle carrying bit 7 of a byte, with no stop request present or pending. The first bit of an accepted byte goes out in the next cycle, and bytes of a frame follow with no gap.
- R4: The progress count is the number of data bits driven with tx_en high, up to and including the cycle in which abort_req is sampled. If this count is below the threshold, tx_en is low from the next cycle on, and the frame is a runt.
- R5: If the progress count has reached the threshold and the request is not on bit 7 of a byte, the current byte is finished. After it comes the raw CRC register (not complemented), bit 0 first, covering every byte sent. No further input byte is accepted.
- R6: A request that reaches the threshold in the cycle carrying bit 7 of a byte starts the raw CRC register in the next cycle, with no padding byte.
- R7: abort_done is a one-cycle pulse in the cycle right after the last bit of a runt or of a corrupted FCS. tx_en is low in that cycle, and the block is then idle.
- R8: A request while idle gives abort_done in the next cycle. in_ready is low in the request cycle, and no bit is sent.
- R9: A request while the normal FCS is being sent is ignored. The normal FCS completes and no abort_done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Frame byte offered by the MAC |
| in_valid | input | 1 | in_data holds a byte of the current frame |
| in_ready | output | 1 | Byte is taken at this edge when in_valid is high |
| abort_req | input | 1 | Orderly stop request, sampled each cycle |
| abort_done | output | 1 | One-cycle pulse after a stop has finished |
| tx_bit | output | 1 | Serial data bit, valid when tx_en is high |
| tx_en | output | 1 | A frame bit is on tx_bit this cycle |

## Verification
A wrong progress count shows up as a stop taking the wrong branch. The stream then ends as a runt where 32 trailing bits were due, or the reverse, and this is visible by the cycle after the request. A wrong CRC register shows only in the 32 trailing bits. Each of those bits is compared with a CRC computed bit by bit in the non-reflected form and then bit-reversed. A stuck bit counter or state shifts the trailing bits by whole bytes, or moves abort_done off the cycle after the last tx_en cycle. Both are found when the frame is compared bit for bit.

// File: rtl/txa_pkg.sv
package txa_pkg;
  localparam int CRC_W = 32;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCS,
    ST_BAD,
    ST_DONE
  } txa_state_e;

  // Reflected CRC-32 step over one byte, data bit 0 first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? CRC_POLY_REFL : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/txa_crc_reg.sv
module txa_crc_reg
  import txa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] base;
  assign base = restart ? '1 : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (step) crc_q <= crc_step_byte(base, data);
  end
endmodule

// File: rtl/txa_progress.sv
module txa_progress #(
  parameter int THRESH = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic reached
);
  localparam int CW = (THRESH > 1) ? $clog2(THRESH) : 1;
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;
  // high when the bit driven in this cycle brings the count to THRESH or more
  assign reached = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (inc && !reached)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txa_shifter.sv
module txa_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         lsb
);
  logic [W-1:0] sh_q;
  assign lsb = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= load_val;
    else if (shift) sh_q <= {1'b0, sh_q[W-1:1]};
  end
endmodule

// File: rtl/tx_orderly_abort.sv
module tx_orderly_abort
  import txa_pkg::*;
#(
  parameter int THRESH_BITS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              abort_req,
  output logic              abort_done,
  output logic              tx_bit,
  output logic              tx_en
);
  localparam int IDX_W = $clog2(CRC_W);
  localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] FCS_LAST  = IDX_W'(CRC_W - 1);

  txa_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q, pend_d;
  logic [CRC_W-1:0] crc_q;
  logic             reached, sh_lsb, sh_load, accept;
  logic [CRC_W-1:0] sh_val;

  // named internal events
  logic at_bnd, fcs_phase, fcs_end;
  logic ev_start, ev_next, ev_runt, ev_defer, ev_bad_start, ev_good_start, ev_idle_abort;

  assign at_bnd    = (st_q == ST_DATA) && (idx_q == BYTE_LAST);
  assign fcs_phase = (st_q == ST_FCS);
  assign fcs_end   = ((st_q == ST_FCS) || (st_q == ST_BAD)) && (idx_q == FCS_LAST);

  assign in_ready = ((st_q == ST_IDLE) && !abort_req) ||
                    (at_bnd && !pend_q && !abort_req);
  assign accept   = in_valid && in_ready;

  assign ev_idle_abort = (st_q == ST_IDLE) && abort_req;
  assign ev_start      = (st_q == ST_IDLE) && accept;
  assign ev_runt       = (st_q == ST_DATA) && abort_req && !pend_q && !reached;
  assign ev_defer      = (st_q == ST_DATA) && !at_bnd && abort_req && !pend_q && reached;
  assign ev_bad_start  = at_bnd && (pend_q || (abort_req && reached));
  assign ev_good_start = at_bnd && !pend_q && !abort_req && !in_valid;
  assign ev_next       = at_bnd && accept;

  assign tx_en      = (st_q == ST_DATA) || (st_q == ST_FCS) || (st_q == ST_BAD);
  assign tx_bit     = tx_en && sh_lsb;
  assign abort_done = (st_q == ST_DONE);

  assign sh_load = ev_start || ev_next || ev_bad_start || ev_good_start;
  always_comb begin
    if (ev_bad_start)       sh_val = crc_q;     // raw register: corrupted FCS
    else if (ev_good_start) sh_val = ~crc_q;    // normal FCS
    else                    sh_val = {{(CRC_W-BYTE_W){1'b0}}, in_data};
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_idle_abort) st_d = ST_DONE;
        else if (ev_start) st_d = ST_DATA;
      end
      ST_DATA: begin
        if (ev_runt)            st_d = ST_DONE;
        else if (ev_bad_start)  st_d = ST_BAD;
        else if (ev_good_start) st_d = ST_FCS;
        if (ev_defer)           pend_d = 1'b1;
        if (st_d != ST_DATA)    pend_d = 1'b0;
      end
      ST_FCS:  if (fcs_end) st_d = ST_IDLE;
      ST_BAD:  if (fcs_end) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (sh_load)    idx_q <= '0;
      else if (tx_en) idx_q <= idx_q + 1'b1;
    end
  end

  txa_crc_reg u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_q == ST_IDLE),
    .step    (accept),
    .data    (in_data),
    .crc_q   (crc_q)
  );

  txa_progress #(.THRESH(THRESH_BITS)) u_prog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q == ST_IDLE),
    .inc     (st_q == ST_DATA),
    .reached (reached)
  );

  txa_shifter #(.W(CRC_W)) u_sh (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (tx_en && !sh_load),
    .lsb      (sh_lsb)
  );
endmodule

// File: rtl/txa_checker.sv
module txa_checker (
  input logic clk,
  input logic rst_n,
  input logic abort_req,
  input logic abort_done,
  input logic tx_en,
  input logic tx_bit,
  input logic in_valid,
  input logic in_ready,
  input logic fcs_phase,
  input logic crc_lsb,
  input logic ev_runt,
  input logic ev_defer,
  input logic ev_bad_start,
  input logic ev_idle_abort
);
  // R3
  accept_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> tx_en);
  // R4
  runt_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_runt |=> (!tx_en && abort_done));
  // R5
  defer_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_defer |=> (tx_en && !abort_done));
  // R6
  bad_fcs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_start |=> (tx_en && tx_bit == $past(crc_lsb)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> !abort_done);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |-> !tx_en);
  // R8
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_abort |=> (abort_done && !tx_en));
  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_abort |-> !in_ready);
  // R9
  fcs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_phase && abort_req) |=> !abort_done);
endmodule

bind tx_orderly_abort txa_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .abort_req     (abort_req),
  .abort_done    (abort_done),
  .tx_en         (tx_en),
  .tx_bit        (tx_bit),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .fcs_phase     (fcs_phase),
  .crc_lsb       (crc_q[0]),
  .ev_runt       (ev_runt),
  .ev_defer      (ev_defer),
  .ev_bad_start  (ev_bad_start),
  .ev_idle_abort (ev_idle_abort)
);

// File: tb/tx_orderly_abort_bench.sv
module tx_orderly_abort_bench;
  localparam int THR = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       abort_req = 1'b0;
  logic       abort_done;
  logic       tx_bit;
  logic       tx_en;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  tx_orderly_abort #(.THRESH_BITS(THR)) u_tx_orderly_abort (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .abort_req(abort_req), .abort_done(abort_done),
    .tx_bit(tx_bit), .tx_en(tx_en)
  );

  logic [7:0] fb [0:127];
  logic       got [0:1199];
  logic       expv[0:1199];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Non-reflected MSB-first CRC, bits fed LSB of each byte first, then bit-reversed.
  function automatic logic [31:0] ref_crc(input int nb);
    logic [31:0] c, r;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < 8; i++) begin
        logic fbk;
        fbk = c[31] ^ fb[b][i];
        c = {c[30:0], 1'b0} ^ (fbk ? 32'h04C11DB7 : 32'h0);
      end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return r;
  endfunction

  // abort_k: index of the tx_en bit during which abort_req is high, -1 for none
  task automatic run_frame(input int nbytes, input int abort_k, input string tag);
    int idx = 0, ng = 0, cyc = 0, ndone = 0, done_cyc = -1, last_en = -1;
    int nexp, nd, nb, mism;
    bit stop_feed = 0, acc, aborted, runt;
    logic [31:0] crc;
    for (int b = 0; b < nbytes; b++) fb[b] = 8'($urandom);
    for (int c = 0; c < nbytes * 8 + 60; c++) begin
      @(negedge clk);
      abort_req = 1'b0;
      if (tx_en) begin
        got[ng] = tx_bit;
        ng++;
        last_en = cyc;
        if (abort_k >= 0 && ng - 1 == abort_k) begin
          abort_req = 1'b1;
          stop_feed = 1;
        end
      end
      if (abort_done) begin ndone++; done_cyc = cyc; end
      in_valid = !stop_feed && (idx < nbytes);
      in_data  = (idx < nbytes) ? fb[idx] : 8'h00;
      #1;
      acc = in_valid && in_ready;
      @(posedge clk);
      if (acc) idx++;
      cyc++;
    end
    abort_req = 1'b0;
    in_valid  = 1'b0;
    nd = nbytes * 8;
    aborted = (abort_k >= 0) && (abort_k < nd);
    runt = aborted && (abort_k + 1 < THR);
    if (!aborted) begin
      crc = ~ref_crc(nbytes);
      for (int j = 0; j < nd; j++) expv[j] = fb[j/8][j%8];
      for (int j = 0; j < 32; j++) expv[nd+j] = crc[j];
      nexp = nd + 32;
    end else if (runt) begin
      for (int j = 0; j <= abort_k; j++) expv[j] = fb[j/8][j%8];
      nexp = abort_k + 1;
    end else begin
      nb = abort_k / 8 + 1;
      crc = ref_crc(nb);
      for (int j = 0; j < nb * 8; j++) expv[j] = fb[j/8][j%8];
      for (int j = 0; j < 32; j++) expv[nb*8+j] = crc[j];
      nexp = nb * 8 + 32;
    end
    mism = 0;
    for (int j = 0; j < nexp && j < ng; j++) if (got[j] !== expv[j]) mism++;
    if (!aborted) begin
      // R2 R3 R9: full frame plus complemented FCS, no completion pulse
      chk(ng == nexp, "R3", {tag, " frame length"}, ng, nexp);
      chk(mism == 0, "R2", {tag, " bit mismatches"}, mism, 0);
      chk(ndone == 0, "R9", {tag, " abort_done count"}, ndone, 0);
    end else if (runt) begin
      chk(ng == nexp, "R4", {tag, " runt length"}, ng, nexp);
      chk(mism == 0, "R4", {tag, " runt bits"}, mism, 0);
      chk(ndone == 1 && done_cyc == last_en + 1, "R7", {tag, " done cycle"}, done_cyc, last_en + 1);
    end else begin
      chk(ng == nexp, (abort_k % 8 == 7) ? "R6" : "R5", {tag, " corrupted length"}, ng, nexp);
      chk(mism == 0, "R5", {tag, " corrupted bits"}, mism, 0);
      chk(ndone == 1 && done_cyc == last_en + 1, "R7", {tag, " done cycle"}, done_cyc, last_en + 1);
    end
  endtask

  task automatic idle_abort();
    @(negedge clk);
    abort_req = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R8", "in_ready during idle request", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    abort_req = 1'b0;
    chk(abort_done == 1'b1 && tx_en == 1'b0, "R8", "idle request done", int'(abort_done), 1);
    @(negedge clk);
    chk(abort_done == 1'b0, "R7", "done pulse width", int'(abort_done), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_en == 0 && abort_done == 0 && in_ready == 1, "R1", "reset state",
        int'({tx_en, abort_done, in_ready}), 1);
    run_frame(64, -1, "plain64");
    run_frame(70, 0, "first-bit");
    run_frame(70, 510, "just-below");
    run_frame(70, 511, "on-boundary");
    run_frame(64, 511, "last-byte-boundary");
    run_frame(70, 512, "just-above");
    run_frame(80, 517, "mid-byte");
    run_frame(66, 66 * 8 + 5, "during-fcs");
    idle_abort();
    for (int n = 0; n < 20; n++) begin
      int nbytes, k;
      nbytes = 1 + int'($urandom % 100);
      if ($urandom % 4 == 0) k = -1;
      else k = int'($urandom % (nbytes * 8 + 32));
      run_frame(nbytes, k, "random");
    end
    idle_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule